// File: doc/BRIEF.md
# TDM Transmit Voice Octet Multiplexer

This block drives a serial TDM transmit line one bit per launch edge of an external line clock. At every frame boundary it sends a programmable number of voice octets, taken in order from an internal voice buffer. It then fills every later octet of the frame with payload bytes pulled over a ready/valid byte interface. Octets go out MSB first, and the first octet of a frame is byte aligned to the frame sync.

The line clock and frame sync are sampled in the system clock domain. Each selected line clock edge is one bit slot, so a gapped or stretched line clock is tolerated. The frame sync is taken either as aligned with the frame overhead or as a lead arriving three launch edges early. A configuration bit moves the launch edge from the rising to the falling edge of the line clock. When a voice slot finds the buffer empty, the block sends an all-ones idle octet and pulses an underflow status output. A payload slot with no payload byte available carries the flag-like fill octet 0x7E.

Top module: `tdm_voice_mux_tx`

## Requirements
- R1: After reset and until the first frame start, tx_data is held at 1, voice_underrun stays 0 and no payload byte is accepted (pay_ready never asserts).
- R2: With cfg_early_sync=0, the launch edge on which tx_sync is sampled high starts a frame, and the MSB of the frame's first octet is driven from that edge. Each later launch edge drives the next bit, MSB first.
- R3: The first min(cfg_voice_cnt,16) octets of each frame are voice octets, taken from the voice buffer in write order; cfg_voice_cnt is a 5-bit count (0 to 31), and any value above 16 acts as 16.
- R4: Every octet after the voice octets is a payload octet, sent as a byte accepted on a pay_valid/pay_ready handshake (exactly one accepted byte per payload octet when pay_valid is high), or 0x7E when pay_valid is low.
- R5: With cfg_early_sync=1, a sync sampled high on one launch edge starts the frame on the third launch edge after it, and the MSB of the first octet is driven from that edge.
- R6: With cfg_clk_invert=0, bits are launched on rising line_clk edges; with cfg_clk_invert=1, they are launched on falling edges.
- R7: A voice slot that finds the buffer empty carries 0xFF, and voice_underrun pulses for exactly one system clock cycle per such slot.
- R8: A sync that arrives in the middle of an octet abandons that octet and restarts the frame at its first voice octet.
- R9: The voice buffer holds 32 octets; voice_ready is low exactly when it is full, and a write offered while it is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; line signals are sampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk | input | 1 | Transmit line clock, possibly gapped |
| tx_sync | input | 1 | Frame sync, sampled on the launch edge |
| cfg_early_sync | input | 1 | 1: sync leads the frame by three launch edges |
| cfg_clk_invert | input | 1 | 1: launch on falling line_clk edges |
| cfg_voice_cnt | input | 5 | Voice octets per frame (values above 16 act as 16) |
| voice_valid | input | 1 | Voice write strobe |
| voice_data | input | 8 | Voice octet to buffer |
| voice_ready | output | 1 | Voice buffer can take an octet |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Payload byte taken this cycle |
| tx_data | output | 1 | Serial transmit data |
| voice_underrun | output | 1 | One-cycle pulse per voice slot with an empty buffer |

## Verification
The assertions assume that line_clk is slow next to clk, so that two selected edges never reach the edge detector on adjacent system cycles. They also assume that tx_sync changes only together with the launching edge, and that configuration inputs change only between frames. The stimulus holds each line clock phase for eight system cycles and changes tx_sync and line_clk in the same step. It changes the configuration, the idle line level and the voice buffer only in the gaps between frames. When the launch edge is switched, the bench changes cfg_clk_invert first and the idle level second, so the level change is never taken as a launch edge.

// File: rtl/tdmv_pkg.sv
package tdmv_pkg;

  localparam logic [7:0] VOICE_FILL = 8'hFF;
  localparam logic [7:0] PAY_FILL   = 8'h7E;
  localparam int         SYNC_LEAD  = 3;

  // Effective voice octet count: requests beyond the limit saturate.
  function automatic int clamp_voice(input int req, input int limit);
    return (req > limit) ? limit : req;
  endfunction

  // Octet chosen for a slot, including both idle fills.
  function automatic logic [7:0] pick_octet(input logic voice_slot,
                                            input logic buf_empty,
                                            input logic [7:0] buf_data,
                                            input logic pay_avail,
                                            input logic [7:0] pay_byte);
    if (voice_slot) return buf_empty ? VOICE_FILL : buf_data;
    return pay_avail ? pay_byte : PAY_FILL;
  endfunction

  // Number of whole or partial octets in a frame of a given bit length.
  function automatic int octets_in(input int bits);
    return (bits + 7) / 8;
  endfunction

endpackage

// File: rtl/tdmv_line_sampler.sv
module tdmv_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_clk,
  input  logic sync_in,
  input  logic invert,
  output logic tick,
  output logic sync_smp
);
  logic [SYNC_STAGES:0]   lc_pipe;
  logic [SYNC_STAGES-1:0] sy_pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lc_pipe[0] <= 1'b0;
      sy_pipe[0] <= 1'b0;
    end else begin
      lc_pipe[0] <= line_clk;
      sy_pipe[0] <= sync_in;
    end
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_lc
    always_ff @(posedge clk) begin
      if (!rst_n) lc_pipe[g] <= 1'b0;
      else        lc_pipe[g] <= lc_pipe[g-1];
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sy
    always_ff @(posedge clk) begin
      if (!rst_n) sy_pipe[g] <= 1'b0;
      else        sy_pipe[g] <= sy_pipe[g-1];
    end
  end

  logic cur_lvl, prev_lvl, rise_evt, fall_evt;
  assign cur_lvl  = lc_pipe[SYNC_STAGES-1];
  assign prev_lvl = lc_pipe[SYNC_STAGES];
  assign rise_evt = cur_lvl & ~prev_lvl;
  assign fall_evt = ~cur_lvl & prev_lvl;
  assign tick     = invert ? fall_evt : rise_evt;
  assign sync_smp = sy_pipe[SYNC_STAGES-1];

  // R6: a launch edge is a single-cycle event
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/tdmv_frame_align.sv
module tdmv_frame_align #(
  parameter int LEAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_smp,
  input  logic early,
  output logic frame_start
);
  logic [LEAD-1:0] lead_line;

  always_ff @(posedge clk) begin
    if (!rst_n)    lead_line[0] <= 1'b0;
    else if (tick) lead_line[0] <= sync_smp;
  end

  for (genvar g = 1; g < LEAD; g++) begin : g_dl
    always_ff @(posedge clk) begin
      if (!rst_n)    lead_line[g] <= 1'b0;
      else if (tick) lead_line[g] <= lead_line[g-1];
    end
  end

  logic delayed_sync;
  assign delayed_sync = lead_line[LEAD-1];
  assign frame_start  = tick & (early ? delayed_sync : sync_smp);

  // R5/R2: frames only begin on a launch edge
  a_r5_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> tick);

endmodule

// File: rtl/tdmv_voice_fifo.sv
module tdmv_voice_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  input  logic             rd_pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      fill;
  logic             do_wr, do_rd;

  assign wr_ready = (fill != (AW+1)'(DEPTH));
  assign rd_empty = (fill == '0);
  assign rd_data  = mem[rd_ptr];
  assign do_wr    = wr_valid & wr_ready;
  assign do_rd    = rd_pop & ~rd_empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R9: occupancy never exceeds the buffer depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
  // R7: the engine never pops an empty buffer
  a_r7_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |-> !rd_empty);

endmodule

// File: rtl/tdmv_serializer.sv
module tdmv_serializer
  import tdmv_pkg::*;
#(
  parameter int MAX_VOICE = 16,
  parameter int CNT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             frame_start,
  input  logic [CNT_W-1:0] voice_n,
  input  logic [7:0]       buf_data,
  input  logic             buf_empty,
  output logic             buf_pop,
  input  logic             pay_valid,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  output logic             tx_data,
  output logic             voice_underrun
);
  localparam int IDX_W = $clog2(MAX_VOICE + 1);

  logic             started;
  logic [2:0]       bit_idx;
  logic [IDX_W-1:0] oct_idx, nxt_idx;
  logic [CNT_W-1:0] n_lat, n_use;
  logic [7:0]       shreg, octet;
  logic             octet_end, load, voice_slot;

  assign octet_end  = started && (bit_idx == 3'd7);
  assign load       = tick && (frame_start || octet_end);
  assign nxt_idx    = frame_start ? '0 :
                      (oct_idx == IDX_W'(MAX_VOICE)) ? oct_idx : oct_idx + 1'b1;
  assign n_use      = frame_start ? voice_n : n_lat;
  assign voice_slot = int'(nxt_idx) < int'(n_use);
  assign octet      = pick_octet(voice_slot, buf_empty, buf_data, pay_valid, pay_data);
  assign buf_pop    = load & voice_slot & ~buf_empty;
  assign pay_ready  = load & ~voice_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started        <= 1'b0;
      bit_idx        <= '0;
      oct_idx        <= '0;
      n_lat          <= '0;
      shreg          <= '0;
      tx_data        <= 1'b1;
      voice_underrun <= 1'b0;
    end else begin
      voice_underrun <= load & voice_slot & buf_empty;
      if (load) begin
        started <= 1'b1;
        bit_idx <= '0;
        oct_idx <= nxt_idx;
        tx_data <= octet[7];
        shreg   <= {octet[6:0], 1'b0};
        if (frame_start) n_lat <= voice_n;
      end else if (tick && started) begin
        bit_idx <= bit_idx + 1'b1;
        tx_data <= shreg[7];
        shreg   <= {shreg[6:0], 1'b0};
      end
    end
  end

  // Voice pops since the latest frame start, for the bound check.
  logic [IDX_W:0] pops_in_frame;
  always_ff @(posedge clk) begin
    if (!rst_n)                   pops_in_frame <= '0;
    else if (load && frame_start) pops_in_frame <= {{IDX_W{1'b0}}, buf_pop};
    else if (buf_pop)             pops_in_frame <= pops_in_frame + 1'b1;
  end

  // R2: the line output moves only right after a launch edge
  a_r2_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(tx_data) |-> $past(tick));
  // R1: idle high until the first frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> tx_data);
  // R4: payload and voice never share one slot
  a_r4_slot_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> (!buf_pop && tick));
  // R3: at most the voice limit is drawn per frame
  a_r3_voice_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pops_in_frame <= (IDX_W+1)'(MAX_VOICE));
  // R7: an underrun pulse lasts one cycle
  a_r7_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    voice_underrun |=> !voice_underrun);

endmodule

// File: rtl/tdm_voice_mux_tx.sv
module tdm_voice_mux_tx
  import tdmv_pkg::*;
#(
  parameter int MAX_VOICE   = 16,
  parameter int FIFO_DEPTH  = 32,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(MAX_VOICE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_clk,
  input  logic             tx_sync,
  input  logic             cfg_early_sync,
  input  logic             cfg_clk_invert,
  input  logic [CNT_W-1:0] cfg_voice_cnt,
  input  logic             voice_valid,
  input  logic [7:0]       voice_data,
  output logic             voice_ready,
  input  logic             pay_valid,
  input  logic [7:0]       pay_data,
  output logic             pay_ready,
  output logic             tx_data,
  output logic             voice_underrun
);
  logic             tick, sync_smp, frame_start;
  logic             buf_pop, buf_empty;
  logic [7:0]       buf_data;
  logic [CNT_W-1:0] voice_n;

  assign voice_n = CNT_W'(clamp_voice(int'(cfg_voice_cnt), MAX_VOICE));

  tdmv_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_clk (line_clk),
    .sync_in  (tx_sync),
    .invert   (cfg_clk_invert),
    .tick     (tick),
    .sync_smp (sync_smp)
  );

  tdmv_frame_align #(.LEAD(SYNC_LEAD)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .sync_smp    (sync_smp),
    .early       (cfg_early_sync),
    .frame_start (frame_start)
  );

  tdmv_voice_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (voice_valid),
    .wr_data  (voice_data),
    .wr_ready (voice_ready),
    .rd_pop   (buf_pop),
    .rd_data  (buf_data),
    .rd_empty (buf_empty)
  );

  tdmv_serializer #(.MAX_VOICE(MAX_VOICE), .CNT_W(CNT_W)) u_ser (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .frame_start    (frame_start),
    .voice_n        (voice_n),
    .buf_data       (buf_data),
    .buf_empty      (buf_empty),
    .buf_pop        (buf_pop),
    .pay_valid      (pay_valid),
    .pay_data       (pay_data),
    .pay_ready      (pay_ready),
    .tx_data        (tx_data),
    .voice_underrun (voice_underrun)
  );

  // R3: the effective count never exceeds the limit
  a_r3_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    int'(voice_n) <= MAX_VOICE);

endmodule

// File: tb/tdm_voice_mux_tx_test.sv
`timescale 1ns/1ps
module tdm_voice_mux_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_clk = 1'b0, tx_sync = 1'b0;
  logic cfg_early_sync = 1'b0, cfg_clk_invert = 1'b0;
  logic [4:0] cfg_voice_cnt = '0;
  logic voice_valid = 1'b0;
  logic [7:0] voice_data = '0;
  logic voice_ready, pay_ready, tx_data, voice_underrun;
  logic pay_valid = 1'b0;
  logic [7:0] pay_data;

  int errors = 0, checks = 0;
  int acc = 0, urun = 0;
  int exp_acc = 0, exp_urun = 0;
  int vwr = 0, vrd = 0;
  int cur_n = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tdm_voice_mux_tx uut (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .tx_sync(tx_sync),
    .cfg_early_sync(cfg_early_sync), .cfg_clk_invert(cfg_clk_invert),
    .cfg_voice_cnt(cfg_voice_cnt), .voice_valid(voice_valid),
    .voice_data(voice_data), .voice_ready(voice_ready),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_ready(pay_ready),
    .tx_data(tx_data), .voice_underrun(voice_underrun));

  function automatic logic [7:0] vbyte(input int i);
    return 8'(i * 37 + 11);
  endfunction
  function automatic logic [7:0] pbyte(input int i);
    return 8'(i * 3 + 5);
  endfunction

  assign pay_data = pbyte(acc);

  always @(posedge clk) begin
    if (pay_valid && pay_ready) acc <= acc + 1;
    if (voice_underrun) urun <= urun + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic set_n(input int n);
    cur_n = n;
    cfg_voice_cnt = 5'(n);
  endtask

  task automatic push_voice(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      voice_valid = 1'b1;
      voice_data  = vbyte(vwr);
      vwr++;
    end
    @(negedge clk);
    voice_valid = 1'b0;
  endtask

  // One frame of len bit slots; captured bits are compared octet by octet.
  task automatic run_frame(input int len, input bit sync_start, input bit sync_lead,
                           input bit chk, input string req);
    logic [7:0] cap [64];
    int nv, bits_in;
    logic [7:0] expb, mask;
    for (int o = 0; o < 64; o++) cap[o] = 8'h00;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      tx_sync  = (sync_start && p == 0) || (sync_lead && p == len - 3);
      line_clk = ~cfg_clk_invert;
      repeat (8) @(negedge clk);
      line_clk = cfg_clk_invert;
      repeat (7) @(negedge clk);
      cap[p/8][7 - (p % 8)] = tx_data;
    end
    @(negedge clk);
    tx_sync = 1'b0;
    if (chk) begin
      nv = (cur_n > 16) ? 16 : cur_n;
      for (int o = 0; o < (len + 7) / 8; o++) begin
        bits_in = (len - o * 8 > 8) ? 8 : len - o * 8;
        mask = 8'hFF << (8 - bits_in);
        if (o < nv) begin
          if (vrd < vwr) begin expb = vbyte(vrd); vrd++; end
          else begin expb = 8'hFF; exp_urun++; end
        end else if (pay_valid) begin
          expb = pbyte(exp_acc); exp_acc++;
        end else expb = 8'h7E;
        check((cap[o] & mask) == (expb & mask), req, cap[o] & mask, expb & mask);
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(tx_data == 1'b1, "R1 idle tx", tx_data, 1);
    check(voice_ready == 1'b1, "R9 ready after reset", voice_ready, 1);
    rst_n = 1'b1;
    // R1: launch edges with no sync leave the line idle
    run_frame(4, 0, 0, 0, "R1");
    check(tx_data == 1'b1, "R1 idle before sync", tx_data, 1);
    check(acc == 0, "R1 no payload taken", acc, 0);
    check(urun == 0, "R1 no underrun", urun, 0);

    // R2 R3 R4: sweep of voice counts, clamp above 16
    for (int n = 0; n <= 18; n++) begin
      int req = (n == 18) ? 31 : n;
      set_n(req);
      pay_valid = (n % 3 != 0);
      push_voice(req > 16 ? 16 : req);
      run_frame(144, 1, 0, 1, "R2/R3/R4 sweep");
    end
    check(acc == exp_acc, "R4 payload handshakes", acc, exp_acc);

    // R8: sync in the middle of an octet restarts the frame
    set_n(2); pay_valid = 1'b1; push_voice(2);
    run_frame(20, 1, 0, 1, "R8 short frame");
    set_n(1); push_voice(1);
    run_frame(64, 1, 0, 1, "R8 restart");

    // R7: buffer runs dry inside the voice slots
    set_n(4); push_voice(2);
    run_frame(64, 1, 0, 1, "R7 underrun fill");
    repeat (4) @(negedge clk);
    check(urun == exp_urun, "R7 underrun pulses", urun, exp_urun);

    // R5: sync leads by three launch edges
    cfg_early_sync = 1'b1; set_n(0); pay_valid = 1'b0;
    run_frame(64, 0, 1, 0, "R5 prime");
    set_n(3); pay_valid = 1'b1; push_voice(3);
    run_frame(64, 0, 1, 1, "R5 early frame");
    set_n(5); push_voice(5);
    run_frame(64, 0, 0, 1, "R5 early frame 2");
    cfg_early_sync = 1'b0;

    // R6: launch on falling edges
    @(negedge clk); cfg_clk_invert = 1'b1;
    repeat (4) @(negedge clk); line_clk = 1'b1;
    repeat (16) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      set_n(2 + k); push_voice(2 + k);
      run_frame(64, 1, 0, 1, "R6 inverted");
    end
    @(negedge clk); cfg_clk_invert = 1'b0;
    repeat (4) @(negedge clk); line_clk = 1'b0;
    repeat (16) @(negedge clk);

    // R9: fill the buffer, offer one more, then drain in order
    push_voice(32);
    check(voice_ready == 1'b0, "R9 full", voice_ready, 0);
    @(negedge clk); voice_valid = 1'b1; voice_data = 8'hA5;
    @(negedge clk); voice_valid = 1'b0;
    set_n(16);
    run_frame(136, 1, 0, 1, "R9 drain 1");
    check(voice_ready == 1'b1, "R9 ready after drain", voice_ready, 1);
    run_frame(136, 1, 0, 1, "R9 drain 2");
    repeat (4) @(negedge clk);
    check(urun == exp_urun, "R9 dropped write not sent", urun, exp_urun);
    check(acc == exp_acc, "R4 final handshakes", acc, exp_acc);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule